// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on an outbound request path. It rewrites request addresses through a set of programmable translation windows and tags each request with an action word. The action word tells the downstream transaction builder which transaction type to emit and which attributes to carry.

Each window holds four things: a 64-bit match value, a 64-bit mask, a 64-bit remap base and a 32-bit action word. A request hits a window when its masked address equals the window's masked match value. The address bits selected by the mask are then replaced by the same bits of the remap base. Requests that hit no window keep their address and take a default action word.

Windows are programmed through a simple 32-bit register port. Each request is looked up in the cycle it is accepted, and the result is held in an output register that uses a valid/ready handshake.

Top module: `obwin_xlate`

## Requirements
- R1: After reset:
  - every window and the default action word read as zero;
  - every window is disabled;
  - `rsp_valid` is low and `req_ready` is high.
- R2: The register map uses byte addresses on `cfg_addr`.
  - Window n occupies the 32 bytes starting at n*0x20. Within that block:
    - 0x00: match bits 31:0 (bit 0 is the enable);
    - 0x04: match bits 63:32;
    - 0x08: remap bits 31:0;
    - 0x0C: remap bits 63:32;
    - 0x10: mask bits 31:0;
    - 0x14: mask bits 63:32;
    - 0x18: action word.
  - The default action word sits at NWIN*0x20-4, which is 0xFC with 8 windows.
  - A write through `cfg_we` takes effect at the clock edge.
  - `cfg_rdata` returns the stored value of the addressed register combinationally.
  - Offset 0x1C of any other window, and any address whose bits 1:0 are not zero, is unmapped. It reads zero and ignores writes.
- R3: Mask bits 15:0 always store and read as zero, so a window covers at least 64 KiB. The low 16 bits of the match and remap values take no part in the lookup.
- R4: A request address A hits an enabled window when (A AND mask) equals (match AND mask). The translated address is (A AND NOT mask) OR (remap AND mask).
- R5: On a hit, the response carries the following:
  - that window's action word, with type in bits 3:0 (0x0 memory, 0x4 I/O, 0x8 config type 0, 0x9 config type 1, 0xC message) and the attribute bits passed through unchanged;
  - `rsp_hit` set to 1;
  - the window index on `rsp_win`.
- R6: On a miss, the response carries:
  - the request address unchanged;
  - the default action word;
  - `rsp_hit` set to 0;
  - `rsp_win` set to 0.
- R7: A window whose enable bit is clear never hits, even if its match and mask would select the address. Writing zero to its match low register disables it.
- R8: When several windows hit, the lowest-numbered window is used.
- R9: A request accepted on a clock edge (`req_valid` and `req_ready` both high) appears on the response outputs with `rsp_valid` high right after that edge. Requests on consecutive cycles give responses on consecutive cycles.
- R10: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold their values and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NWIN)+5 | Register byte address (write and read) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Translated response valid |
| rsp_ready | input | 1 | Downstream accepts the response |
| rsp_addr | output | 64 | Translated address |
| rsp_action | output | 32 | Action word of the hit window or the default |
| rsp_hit | output | 1 | Request hit a window |
| rsp_win | output | $clog2(NWIN) | Index of the hit window |

## Verification
The bench targets the following corner cases:
- A window that matches but is disabled. A design that ignores the enable bit would translate that address.
- Two overlapping enabled windows. A design with reversed priority would report the higher index and its remap.
- A match value and remap base with junk in their low 16 bits, and a mask written as all ones. A design that stores the low mask bits would either miss or corrupt the low address bits.
- A response stalled by `rsp_ready` while a second request waits. A design with a wrong ready term would either drop the held response or swallow the waiting request.

// File: rtl/obwin_xlate.sv
`timescale 1ns/1ps
module obwin_xlate #(
  parameter int NWIN      = 8,
  parameter int GRAN_BITS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NWIN)+4:0]   cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [63:0]               req_addr,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [63:0]               rsp_addr,
  output logic [31:0]               rsp_action,
  output logic                      rsp_hit,
  output logic [$clog2(NWIN)-1:0]   rsp_win
);
  localparam int WW  = $clog2(NWIN);
  localparam int RAW = WW + 5;
  localparam logic [RAW-1:0] DFLT_ADDR = RAW'(NWIN * 32 - 4);
  localparam logic [63:0] GRAN_KEEP = {{(64-GRAN_BITS){1'b1}}, {GRAN_BITS{1'b0}}};

  logic [63:0] match_q [NWIN];
  logic [63:0] remap_q [NWIN];
  logic [63:0] mask_q  [NWIN];
  logic [31:0] act_q   [NWIN];
  logic [31:0] dflt_q;

  wire [WW-1:0] c_win  = cfg_addr[RAW-1:5];
  wire [2:0]    c_off  = cfg_addr[4:2];
  wire          c_al   = (cfg_addr[1:0] == 2'b00);
  wire          c_dflt = c_al && (cfg_addr == DFLT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        match_q[i] <= '0;
        remap_q[i] <= '0;
        mask_q[i]  <= '0;
        act_q[i]   <= '0;
      end
      dflt_q <= '0;
    end else if (cfg_we && c_al) begin
      if (c_dflt) dflt_q <= cfg_wdata;
      for (int i = 0; i < NWIN; i++) begin
        if (c_win == WW'(i)) begin
          case (c_off)
            3'd0: match_q[i][31:0]  <= cfg_wdata;
            3'd1: match_q[i][63:32] <= cfg_wdata;
            3'd2: remap_q[i][31:0]  <= cfg_wdata;
            3'd3: remap_q[i][63:32] <= cfg_wdata;
            3'd4: mask_q[i][31:0]   <= cfg_wdata & GRAN_KEEP[31:0];
            3'd5: mask_q[i][63:32]  <= cfg_wdata & GRAN_KEEP[63:32];
            3'd6: act_q[i]          <= cfg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (c_dflt) cfg_rdata = dflt_q;
    else if (c_al) begin
      case (c_off)
        3'd0: cfg_rdata = match_q[c_win][31:0];
        3'd1: cfg_rdata = match_q[c_win][63:32];
        3'd2: cfg_rdata = remap_q[c_win][31:0];
        3'd3: cfg_rdata = remap_q[c_win][63:32];
        3'd4: cfg_rdata = mask_q[c_win][31:0];
        3'd5: cfg_rdata = mask_q[c_win][63:32];
        3'd6: cfg_rdata = act_q[c_win];
        default: cfg_rdata = '0;
      endcase
    end
  end

  logic          lk_hit;
  logic [WW-1:0] lk_win;
  logic [63:0]   lk_addr;
  logic [31:0]   lk_act;

  always_comb begin
    lk_hit = 1'b0;
    lk_win = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match_q[i][0] && (((req_addr ^ match_q[i]) & mask_q[i]) == 64'd0)) begin
        lk_hit = 1'b1;
        lk_win = WW'(i);
      end
    end
  end

  assign lk_addr = lk_hit ? ((req_addr & ~mask_q[lk_win]) | (remap_q[lk_win] & mask_q[lk_win]))
                          : req_addr;
  assign lk_act  = lk_hit ? act_q[lk_win] : dflt_q;

  assign req_ready = !rsp_valid || rsp_ready;
  wire accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_action <= '0;
      rsp_hit    <= 1'b0;
      rsp_win    <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr   <= lk_addr;
        rsp_action <= lk_act;
        rsp_hit    <= lk_hit;
        rsp_win    <= lk_win;
      end
    end
  end

  logic [63:0] chk_addr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_addr <= '0;
    else if (accept) chk_addr <= req_addr;
  end

  a_r9_issue: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_action)
                                && $stable(rsp_hit) && $stable(rsp_win));

  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  a_r3_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr[GRAN_BITS-1:0] == chk_addr[GRAN_BITS-1:0]);

  a_r6_miss_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> (rsp_addr == chk_addr) && (rsp_win == '0));
endmodule

// File: tb/sim_obwin_xlate.sv
`timescale 1ns/1ps
module sim_obwin_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic [31:0] rsp_action;
  logic        rsp_hit;
  logic [2:0]  rsp_win;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] m_match [8];
  logic [63:0] m_remap [8];
  logic [63:0] m_mask  [8];
  logic [31:0] m_act   [8];
  logic [31:0] m_dflt;

  obwin_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_action(rsp_action),
    .rsp_hit(rsp_hit), .rsp_win(rsp_win)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 8'hFC) m_dflt = d;
    else if (a[1:0] == 2'b00) begin
      case (a[4:2])
        3'd0: m_match[a[7:5]][31:0]  = d;
        3'd1: m_match[a[7:5]][63:32] = d;
        3'd2: m_remap[a[7:5]][31:0]  = d;
        3'd3: m_remap[a[7:5]][63:32] = d;
        3'd4: m_mask[a[7:5]][31:0]   = d & 32'hFFFF_0000;
        3'd5: m_mask[a[7:5]][63:32]  = d;
        3'd6: m_act[a[7:5]]          = d;
        default: ;
      endcase
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic model(input logic [63:0] a, output logic [63:0] oa, output logic [31:0] oact,
                       output logic oh, output logic [2:0] ow);
    oh = 0; ow = 0; oa = a; oact = m_dflt;
    for (int i = 7; i >= 0; i--) begin
      if (m_match[i][0] && ((a & m_mask[i]) == (m_match[i] & m_mask[i]))) begin
        oh = 1; ow = 3'(i);
        oa = (a & ~m_mask[i]) | (m_remap[i] & m_mask[i]);
        oact = m_act[i];
      end
    end
  endtask

  task automatic rsp_chk(input logic [63:0] a, input string tag);
    logic [63:0] ea; logic [31:0] eact; logic eh; logic [2:0] ew;
    model(a, ea, eact, eh, ew);
    chk(rsp_valid == 1'b1, {tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_addr == ea, {tag, " addr"}, rsp_addr, ea);
    chk(rsp_action == eact, {tag, " action"}, 64'(rsp_action), 64'(eact));
    chk(rsp_hit == eh, {tag, " hit"}, 64'(rsp_hit), 64'(eh));
    chk(rsp_win == ew, {tag, " win"}, 64'(rsp_win), 64'(ew));
  endtask

  task automatic send(input logic [63:0] a, input string tag);
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    rsp_chk(a, tag);
  endtask

  task automatic t_reset();
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    rd_chk(8'h00, 32'h0, "R1 match lo");
    rd_chk(8'h18, 32'h0, "R1 action");
    rd_chk(8'hFC, 32'h0, "R1 default");
    send(64'h0000_0012_3456_789A, "R1 miss after reset");
  endtask

  task automatic t_regmap();
    wr(8'h64, 32'hDEAD_BEEF);
    rd_chk(8'h64, 32'hDEAD_BEEF, "R2 win3 match hi");
    wr(8'h78, 32'h0000_08F4);
    rd_chk(8'h78, 32'h0000_08F4, "R2 win3 action");
    wr(8'h7C, 32'h0000_1234);
    rd_chk(8'h7C, 32'h0, "R2 unmapped offset");
    wr(8'h61, 32'hFFFF_FFFF);
    rd_chk(8'h61, 32'h0, "R2 misaligned");
    rd_chk(8'h60, 32'h0, "R2 misaligned write ignored");
    wr(8'hFC, 32'h0000_0A80);
    rd_chk(8'hFC, 32'h0000_0A80, "R2 default action");
  endtask

  task automatic t_hit();
    wr(8'h00, 32'h3400_0001); wr(8'h04, 32'h0000_0012);
    wr(8'h08, 32'h8000_0000); wr(8'h0C, 32'h0);
    wr(8'h10, 32'hFF00_0000); wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0000_0004);
    send(64'h0000_0012_34AB_CDEF, "R4 R5 hit win0");
    chk(rsp_addr == 64'h0000_0000_80AB_CDEF, "R4 fixed translation", rsp_addr, 64'h80AB_CDEF);
  endtask

  task automatic t_miss();
    send(64'h0000_0099_0000_1234, "R6 miss default");
    chk(rsp_action == 32'h0000_0A80, "R6 fixed default", 64'(rsp_action), 64'h0A80);
  endtask

  task automatic t_enable();
    wr(8'h20, 32'h5000_0000); wr(8'h2C, 32'h0000_0001);
    wr(8'h30, 32'hF000_0000); wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h38, 32'h0000_0008);
    send(64'h0000_0000_5123_4567, "R7 disabled no hit");
    chk(rsp_hit == 1'b0, "R7 disabled hit flag", 64'(rsp_hit), 64'd0);
    wr(8'h20, 32'h5000_0001);
    send(64'h0000_0000_5123_4567, "R7 enabled hit");
    chk(rsp_addr == 64'h0000_0001_0123_4567, "R4 win1 remap", rsp_addr, 64'h1_0123_4567);
    for (int k = 0; k < 7; k++) wr(8'h20 + 8'(k * 4), 32'h0);
    send(64'h0000_0000_5123_4567, "R7 zeroed window");
    chk(rsp_hit == 1'b0, "R7 zeroed no hit", 64'(rsp_hit), 64'd0);
  endtask

  task automatic t_priority();
    wr(8'h40, 32'h7000_0001); wr(8'h50, 32'hFFFF_0000); wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h48, 32'hA000_0000); wr(8'h58, 32'h0000_0009);
    wr(8'hA0, 32'h7000_0001); wr(8'hB0, 32'hFFFF_0000); wr(8'hB4, 32'hFFFF_FFFF);
    wr(8'hA8, 32'hB000_0000); wr(8'hB8, 32'h0000_000C);
    send(64'h0000_0000_7000_1234, "R8 lowest wins");
    chk(rsp_win == 3'd2, "R8 win index", 64'(rsp_win), 64'd2);
    wr(8'h40, 32'h0);
    send(64'h0000_0000_7000_1234, "R8 next window");
    chk(rsp_win == 3'd5 && rsp_action == 32'hC, "R5 message window", 64'(rsp_win), 64'd5);
  endtask

  task automatic t_gran();
    wr(8'hC0, 32'h6000_FFFF); wr(8'hD0, 32'hFFFF_FFFF); wr(8'hD4, 32'hFFFF_FFFF);
    wr(8'hC8, 32'h0002_FFFF); wr(8'hD8, 32'h0000_0000);
    rd_chk(8'hD0, 32'hFFFF_0000, "R3 mask low bits zero");
    rd_chk(8'hC0, 32'h6000_FFFF, "R3 match readback");
    send(64'h0000_0000_6000_0042, "R3 coarse window");
    chk(rsp_addr == 64'h0000_0000_0002_0042, "R3 low bits kept", rsp_addr, 64'h2_0042);
  endtask

  task automatic t_stall();
    logic [63:0] a1, a2;
    a1 = 64'h0000_0012_3400_0010;
    a2 = 64'h0000_0000_7000_5555;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = a1;
    @(negedge clk);
    req_addr = a2;
    rsp_chk(a1, "R9 first response");
    chk(req_ready == 1'b0, "R10 not ready", 64'(req_ready), 64'd0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      rsp_chk(a1, "R10 held response");
    end
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R10 ready with rsp_ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_chk(a2, "R10 waiting request");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_stream();
    logic [63:0] a1, a2;
    a1 = 64'h0000_0000_6000_1111;
    a2 = 64'h0000_00AB_0000_2222;
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_addr = a1;
    @(negedge clk);
    req_addr = a2;
    rsp_chk(a1, "R9 back to back 1");
    @(negedge clk);
    req_valid = 1'b0;
    rsp_chk(a2, "R9 back to back 2");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_match[i] = '0; m_remap[i] = '0; m_mask[i] = '0; m_act[i] = '0;
    end
    m_dflt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_hit();
    t_miss();
    t_enable();
    t_priority();
    t_gran();
    t_stall();
    t_stream();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end
endmodule